// File: doc/BRIEF.md
# Terminal Event Pulse Generator

This block turns single-cycle event strobes from a serial bus terminal into fixed-width discrete output pulses for external hardware. In terminal mode, one shared output pin pulses either when a message touches a data table whose 4-bit pulse field carries the trigger code, or when a valid broadcast command arrives. A control bit picks which of the two sources is used. A second control bit turns both sources off. A separate pin gives a longer pulse when a reset mode command is received.

In controller mode the shared pin changes meaning. It becomes a level that latches when a bus jam is detected. The same event drives a halt flag that stops the controller. Both stay set until the CPU strobes a clear input. A mode change or a synchronous reset aborts every running pulse and drops the jam state.

The pulse widths are parameters counted in clock cycles. At a 50 MHz clock the defaults of 5 and 20 cycles give 100 ns and 400 ns.

Top module: `term_evt_pulse_gen`

## Requirements
- R1: After reset, `pulse_jam_o`, `rst_pulse_o` and `halt_o` are all 0 and the block is in terminal mode.
- R2: In terminal mode (`ctrl_mode_i`=0) with `trig_sel_i`=0, a `tbl_access_i` strobe whose `tbl_code_i` equals 14 drives `pulse_jam_o` high for exactly SHORT_W cycles (default 5), starting in the cycle after the strobe. Any other code value gives no pulse.
- R3: In terminal mode with `trig_sel_i`=1, a `bcast_cmd_i` strobe gives the same SHORT_W-cycle pulse. Table accesses are ignored while `trig_sel_i`=1, and broadcast strobes are ignored while `trig_sel_i`=0.
- R4: While `tag_dis_i`=1, no terminal-mode event starts a pulse on `pulse_jam_o`.
- R5: In terminal mode, a `rst_cmd_i` strobe drives `rst_pulse_o` high for exactly RST_W cycles (default 20), starting in the cycle after the strobe.
- R6: In controller mode (`ctrl_mode_i`=1), reset-command, table and broadcast strobes produce no pulse.
- R7: In controller mode, a `bus_jam_i` strobe sets `pulse_jam_o` and `halt_o` from the next cycle. Both hold until `cpu_clr_i` is asserted, and both are 0 in the cycle after the clear.
- R8: When `cpu_clr_i` and `bus_jam_i` are asserted in the same cycle, the clear wins and `halt_o` stays 0.
- R9: A trigger that arrives while a pulse is running restarts its width count. The output then stays high for the full width after the last trigger, with no gap.
- R10: A synchronous reset (`srst_i`) or a change of `ctrl_mode_i` ends every running pulse and clears the jam state from the next cycle. Events in the cycle of the mode change are dropped.
- R11: In terminal mode `bus_jam_i` has no effect, and `halt_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| srst_i | input | 1 | Synchronous reset: aborts pulses and clears jam |
| ctrl_mode_i | input | 1 | 0 = terminal mode, 1 = controller mode |
| trig_sel_i | input | 1 | 0 = table pulse code triggers, 1 = broadcast command triggers |
| tag_dis_i | input | 1 | 1 = suppress terminal-mode pulses on the shared pin |
| tbl_access_i | input | 1 | Single-cycle strobe: a message accessed a data table |
| tbl_code_i | input | CODE_W | Pulse field of the accessed table, valid with the strobe |
| bcast_cmd_i | input | 1 | Single-cycle strobe: valid broadcast command received |
| rst_cmd_i | input | 1 | Single-cycle strobe: reset mode command received |
| bus_jam_i | input | 1 | Single-cycle strobe: bus jam detected |
| cpu_clr_i | input | 1 | Single-cycle CPU clear of the jam and halt state |
| pulse_jam_o | output | 1 | Shared pin: event pulse in terminal mode, jam level in controller mode |
| rst_pulse_o | output | 1 | Reset-command pulse |
| halt_o | output | 1 | Controller halt flag |

## Verification
The assertions check on every cycle the rules that tie outputs to one earlier cycle. The reset-command pulse only begins after a reset-command strobe in terminal mode. A pin rise in terminal mode needs the disable bit low. A clear or a synchronous reset drops everything in the next cycle. A latched jam holds in controller mode and never appears in terminal mode. The exact pulse widths cannot be shown by a one-cycle property, so only the bench scenarios show them. The same holds for the restart on retrigger, the choice between trigger sources, the rejection of codes other than 14 and the dropping of events in a mode-change cycle.

// File: rtl/tepg_pkg.sv
package tepg_pkg;
  typedef enum logic {
    MODE_TERM = 1'b0,
    MODE_CTRL = 1'b1
  } op_mode_e;

  localparam int unsigned NUM_PULSE = 2;
  localparam int unsigned IDX_SHORT = 0;
  localparam int unsigned IDX_RST   = 1;
endpackage

// File: rtl/tepg_trig_sel.sv
module tepg_trig_sel
  import tepg_pkg::*;
#(
  parameter int unsigned CODE_W     = 4,
  parameter int unsigned MATCH_CODE = 14
) (
  input  op_mode_e          mode_i,
  input  logic              kill_i,
  input  logic              trig_sel_i,
  input  logic              tag_dis_i,
  input  logic              tbl_access_i,
  input  logic [CODE_W-1:0] tbl_code_i,
  input  logic              bcast_cmd_i,
  input  logic              rst_cmd_i,
  output logic              short_trig_o,
  output logic              rst_trig_o
);
  logic term_ok;
  logic code_hit;
  logic src_hit;

  assign term_ok  = (mode_i == MODE_TERM) && !kill_i;
  assign code_hit = tbl_access_i && (tbl_code_i == CODE_W'(MATCH_CODE));
  assign src_hit  = trig_sel_i ? bcast_cmd_i : code_hit;

  assign short_trig_o = term_ok && !tag_dis_i && src_hit;
  assign rst_trig_o   = term_ok && rst_cmd_i;
endmodule

// File: rtl/tepg_pulse_stretch.sv
module tepg_pulse_stretch #(
  parameter int unsigned WIDTH = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kill_i,
  input  logic trig_i,
  output logic active_o
);
  localparam int unsigned CW = $clog2(WIDTH + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (kill_i) begin
      cnt_q <= '0;
    end else if (trig_i) begin
      cnt_q <= CW'(WIDTH);  // retrigger restarts
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign active_o = (cnt_q != '0);
endmodule

// File: rtl/tepg_jam_latch.sv
module tepg_jam_latch
  import tepg_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     kill_i,
  input  op_mode_e mode_i,
  input  logic     jam_i,
  input  logic     clr_i,
  output logic     jam_o
);
  logic jam_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      jam_q <= 1'b0;
    end else if (kill_i || clr_i) begin
      jam_q <= 1'b0;  // clear beats same-cycle jam
    end else if (jam_i && (mode_i == MODE_CTRL)) begin
      jam_q <= 1'b1;
    end
  end

  assign jam_o = jam_q;
endmodule

// File: rtl/term_evt_pulse_gen.sv
module term_evt_pulse_gen
  import tepg_pkg::*;
#(
  parameter int unsigned SHORT_W    = 5,
  parameter int unsigned RST_W      = 20,
  parameter int unsigned CODE_W     = 4,
  parameter int unsigned MATCH_CODE = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              srst_i,
  input  logic              ctrl_mode_i,
  input  logic              trig_sel_i,
  input  logic              tag_dis_i,
  input  logic              tbl_access_i,
  input  logic [CODE_W-1:0] tbl_code_i,
  input  logic              bcast_cmd_i,
  input  logic              rst_cmd_i,
  input  logic              bus_jam_i,
  input  logic              cpu_clr_i,
  output logic              pulse_jam_o,
  output logic              rst_pulse_o,
  output logic              halt_o
);
  op_mode_e mode_q;
  op_mode_e mode_d;
  logic     kill;
  logic     short_trig;
  logic     rst_trig;
  logic     jam;
  logic [NUM_PULSE-1:0] trig_vec;
  logic [NUM_PULSE-1:0] act_vec;

  assign mode_d = ctrl_mode_i ? MODE_CTRL : MODE_TERM;
  assign kill   = srst_i || (mode_d != mode_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_TERM;
    else         mode_q <= mode_d;
  end

  tepg_trig_sel #(
    .CODE_W    (CODE_W),
    .MATCH_CODE(MATCH_CODE)
  ) u_trig_sel (
    .mode_i      (mode_q),
    .kill_i      (kill),
    .trig_sel_i  (trig_sel_i),
    .tag_dis_i   (tag_dis_i),
    .tbl_access_i(tbl_access_i),
    .tbl_code_i  (tbl_code_i),
    .bcast_cmd_i (bcast_cmd_i),
    .rst_cmd_i   (rst_cmd_i),
    .short_trig_o(short_trig),
    .rst_trig_o  (rst_trig)
  );

  assign trig_vec[IDX_SHORT] = short_trig;
  assign trig_vec[IDX_RST]   = rst_trig;

  for (genvar i = 0; i < NUM_PULSE; i++) begin : g_pulse
    tepg_pulse_stretch #(
      .WIDTH((i == IDX_SHORT) ? SHORT_W : RST_W)
    ) u_stretch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .kill_i  (kill),
      .trig_i  (trig_vec[i]),
      .active_o(act_vec[i])
    );
  end

  tepg_jam_latch u_jam (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .kill_i(kill),
    .mode_i(mode_q),
    .jam_i (bus_jam_i),
    .clr_i (cpu_clr_i),
    .jam_o (jam)
  );

  assign pulse_jam_o = (mode_q == MODE_CTRL) ? jam : act_vec[IDX_SHORT];
  assign rst_pulse_o = act_vec[IDX_RST];
  assign halt_o      = jam;
endmodule

// File: rtl/tepg_chk.sv
module tepg_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic srst_i,
  input logic ctrl_mode_i,
  input logic tag_dis_i,
  input logic rst_cmd_i,
  input logic cpu_clr_i,
  input logic pulse_jam_o,
  input logic rst_pulse_o,
  input logic halt_o
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!pulse_jam_o && !rst_pulse_o && !halt_o));

  // R5 R6
  rst_pulse_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_pulse_o) |-> ($past(rst_cmd_i) && !$past(ctrl_mode_i)));

  // R4
  tag_dis_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(pulse_jam_o) && !$past(ctrl_mode_i)) |-> !$past(tag_dis_i));

  // R7
  jam_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_o && ctrl_mode_i && !cpu_clr_i && !srst_i) |=> halt_o);

  // R7
  halt_on_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> pulse_jam_o);

  // R8
  clr_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_clr_i |=> !halt_o);

  // R10
  srst_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> (!pulse_jam_o && !rst_pulse_o && !halt_o));

  // R11
  term_no_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_mode_i && !$past(ctrl_mode_i)) |-> !halt_o);
endmodule

bind term_evt_pulse_gen tepg_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .srst_i     (srst_i),
  .ctrl_mode_i(ctrl_mode_i),
  .tag_dis_i  (tag_dis_i),
  .rst_cmd_i  (rst_cmd_i),
  .cpu_clr_i  (cpu_clr_i),
  .pulse_jam_o(pulse_jam_o),
  .rst_pulse_o(rst_pulse_o),
  .halt_o     (halt_o)
);

// File: tb/term_evt_pulse_gen_tb.sv
`timescale 1ns/1ps
module term_evt_pulse_gen_tb;
  localparam int SW = 5;
  localparam int RW = 20;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic srst_i = 0, ctrl_mode_i = 0, trig_sel_i = 0, tag_dis_i = 0;
  logic tbl_access_i = 0, bcast_cmd_i = 0, rst_cmd_i = 0, bus_jam_i = 0, cpu_clr_i = 0;
  logic [3:0] tbl_code_i = '0;
  logic pulse_jam_o, rst_pulse_o, halt_o;

  always #2.5 clk_i = ~clk_i;

  term_evt_pulse_gen u_dut (.*);

  typedef struct {
    int    cyc;
    logic  pj;
    logic  rp;
    logic  hl;
    string req;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  // monitor
  always @(negedge clk_i) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      exp_t x;
      x = q.pop_front();
      checks++;
      if (x.cyc != cyc) begin
        fails++;
        $display("FAIL %s: sample for cycle %0d missed (now %0d)", x.req, x.cyc, cyc);
      end else if ({pulse_jam_o, rst_pulse_o, halt_o} !== {x.pj, x.rp, x.hl}) begin
        fails++;
        $display("FAIL %s: cyc %0d act pj/rp/hl=%b%b%b exp=%b%b%b", x.req, cyc,
                 pulse_jam_o, rst_pulse_o, halt_o, x.pj, x.rp, x.hl);
      end
    end
  end

  task automatic push(input int from, input int n, input logic pj, input logic rp,
                      input logic hl, input string req);
    for (int k = 0; k < n; k++) begin
      exp_t x;
      x.cyc = from + k; x.pj = pj; x.rp = rp; x.hl = hl; x.req = req;
      q.push_back(x);
    end
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic clr_ev();
    tbl_access_i = 0; bcast_cmd_i = 0; rst_cmd_i = 0;
    bus_jam_i = 0; cpu_clr_i = 0; srst_i = 0; tbl_code_i = '0;
  endtask

  // drive one strobe at the current negedge; returns first output cycle
  task automatic set_ev(input int kind, input logic [3:0] code, output int e);
    case (kind)
      0: begin tbl_access_i = 1; tbl_code_i = code; end
      1: bcast_cmd_i = 1;
      2: rst_cmd_i = 1;
      3: bus_jam_i = 1;
      4: cpu_clr_i = 1;
      default: srst_i = 1;
    endcase
    e = cyc + 1;
  endtask

  initial begin
    int e;
    repeat (3) @(negedge clk_i);
    // R1: reset state
    push(cyc + 1, 1, 0, 0, 0, "R1");
    @(negedge clk_i); rst_ni = 1;
    push(cyc + 1, 3, 0, 0, 0, "R1");
    drain();

    // R2: code 14 pulses for SW cycles
    set_ev(0, 4'd14, e);
    push(e, SW, 1, 0, 0, "R2"); push(e + SW, 3, 0, 0, 0, "R2");
    @(negedge clk_i); clr_ev(); drain();
    // R2: code 13 ignored
    set_ev(0, 4'd13, e);
    push(e, SW + 2, 0, 0, 0, "R2");
    @(negedge clk_i); clr_ev(); drain();

    // R3: broadcast source
    trig_sel_i = 1;
    set_ev(1, 4'd0, e);
    push(e, SW, 1, 0, 0, "R3"); push(e + SW, 2, 0, 0, 0, "R3");
    @(negedge clk_i); clr_ev(); drain();
    set_ev(0, 4'd14, e);
    push(e, SW + 1, 0, 0, 0, "R3");
    @(negedge clk_i); clr_ev(); drain();
    trig_sel_i = 0;
    set_ev(1, 4'd0, e);
    push(e, SW + 1, 0, 0, 0, "R3");
    @(negedge clk_i); clr_ev(); drain();

    // R4: tag disable
    tag_dis_i = 1;
    set_ev(0, 4'd14, e);
    push(e, SW + 1, 0, 0, 0, "R4");
    @(negedge clk_i); clr_ev(); drain();
    trig_sel_i = 1;
    set_ev(1, 4'd0, e);
    push(e, SW + 1, 0, 0, 0, "R4");
    @(negedge clk_i); clr_ev(); drain();
    trig_sel_i = 0; tag_dis_i = 0;

    // R5: reset command pulse
    set_ev(2, 4'd0, e);
    push(e, RW, 0, 1, 0, "R5"); push(e + RW, 2, 0, 0, 0, "R5");
    @(negedge clk_i); clr_ev(); drain();

    // R9: retrigger three cycles later
    set_ev(0, 4'd14, e);
    push(e, SW + 3, 1, 0, 0, "R9"); push(e + SW + 3, 2, 0, 0, 0, "R9");
    @(negedge clk_i); clr_ev();
    @(negedge clk_i);
    @(negedge clk_i); tbl_access_i = 1; tbl_code_i = 4'd14;
    @(negedge clk_i); clr_ev(); drain();

    // R11: jam ignored in terminal mode
    set_ev(3, 4'd0, e);
    push(e, 4, 0, 0, 0, "R11");
    @(negedge clk_i); clr_ev(); drain();

    // R10: srst aborts running pulse
    set_ev(0, 4'd14, e);
    push(e, 2, 1, 0, 0, "R10");
    @(negedge clk_i); clr_ev();
    @(negedge clk_i); srst_i = 1;
    push(e + 2, 3, 0, 0, 0, "R10");
    @(negedge clk_i); clr_ev(); drain();

    // R10: mode change aborts reset pulse
    set_ev(2, 4'd0, e);
    push(e, 3, 0, 1, 0, "R10");
    @(negedge clk_i); clr_ev();
    @(negedge clk_i);
    @(negedge clk_i); ctrl_mode_i = 1;
    push(e + 3, 3, 0, 0, 0, "R10");
    drain();

    // R6: controller mode ignores terminal events
    set_ev(2, 4'd0, e);
    push(e, 4, 0, 0, 0, "R6");
    @(negedge clk_i); clr_ev(); drain();
    set_ev(0, 4'd14, e);
    push(e, 4, 0, 0, 0, "R6");
    @(negedge clk_i); clr_ev(); drain();

    // R7: jam latches until CPU clear
    set_ev(3, 4'd0, e);
    push(e, 8, 1, 0, 1, "R7");
    @(negedge clk_i); clr_ev();
    repeat (7) @(negedge clk_i);
    set_ev(4, 4'd0, e);
    push(e, 2, 0, 0, 0, "R7");
    @(negedge clk_i); clr_ev(); drain();

    // R8: clear beats same-cycle jam
    bus_jam_i = 1; cpu_clr_i = 1; e = cyc + 1;
    push(e, 3, 0, 0, 0, "R8");
    @(negedge clk_i); clr_ev(); drain();

    // R10: srst clears jam
    set_ev(3, 4'd0, e);
    push(e, 2, 1, 0, 1, "R10");
    @(negedge clk_i); clr_ev();
    @(negedge clk_i); srst_i = 1;
    push(e + 2, 2, 0, 0, 0, "R10");
    @(negedge clk_i); clr_ev(); drain();

    // R10: mode change clears jam, drops same-cycle reset command
    set_ev(3, 4'd0, e);
    push(e, 2, 1, 0, 1, "R10");
    @(negedge clk_i); clr_ev();
    @(negedge clk_i); ctrl_mode_i = 0; rst_cmd_i = 1;
    push(e + 2, 4, 0, 0, 0, "R10");
    @(negedge clk_i); clr_ev(); drain();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: act=timeout exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule